// File: doc/BRIEF.md
# Receive Frame Accept Filter

This block sits behind the receive MAC of one Ethernet port. It decides, at the end of every frame, whether the frame is kept or thrown away, and it raises a receive interrupt. The MAC delivers a byte-valid stream with start-of-frame and end-of-frame markers. Four error flags arrive with the end-of-frame marker: FIFO overflow, bad CRC, oversize and undersize. The block does not compute CRC, match addresses or buffer data. It only rules on frames and reports events.

An 8-bit command register sets the behaviour. Each of the low four bits chooses, for one error class, whether an errored frame is kept or dropped. The same bits also enable the interrupt for that class. Bit 4 turns on an early indication after the twelfth byte of a frame. Bit 5 turns on a good-frame indication, intended for debugging. Bits 7:6 hold an address match mode, which is only stored and read back here.

A separate global bit masks the interrupt output completely. Events are collected in a sticky status register that software clears by writing ones. The interrupt stays high while any status bit is set, unless the global mask bit is high.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset the command register, the global mask bit and the status register read 0, and every output is low.
- R2: Register address 0 holds the command register and all 8 of its bits read back as written, including the match-mode bits 7:6. Address 1 bit 0 holds the global interrupt mask bit. Address 2 reads the status register in bits 5:0. Unused addresses and unused bits read 0.
- R3: The command register bits map to error classes as follows: bit 0 overflow, bit 1 CRC, bit 2 oversize, bit 3 undersize. If a frame carries a flagged class whose bit is 1, that class alone does not stop the frame from being kept. `frmDone` pulses for one cycle, one clock after the cycle in which `eofIn` is accepted. `frmKeep` is high in that same cycle when the frame is kept.
- R4: A frame carrying several error flags is dropped if any flagged class has its command bit at 0. Such a frame still produces only one discard pulse.
- R5: `discardPulse` is high for exactly one cycle, coinciding with `frmDone`, for each dropped frame. It is never high for a kept frame.
- R6: With command bit 4 set, `earlyPulse` is high combinationally in the cycle the twelfth byte of a frame is accepted, including when that byte also carries `eofIn`. It fires once per frame. It does not fire for a frame shorter than 12 bytes. It does not fire when bit 4 is 0. `sofIn` restarts the byte count.
- R7: With command bit 5 set, `goodPulse` is high alongside `frmDone` for a frame with no error flags. Such a frame is always kept.
- R8: The status register bits are: bits 3:0 for the error classes in R3 order, bit 4 for the early indication and bit 5 for a good frame. A bit is set in the clock after its event when its command bit is 1. For an error class the event is the frame ending with that flag. For the early and good bits the event is the pulse.
- R9: `rxIrq` is high while any status bit is set and the global mask bit is 0. It is low while the mask bit is 1.
- R10: Writing to address 2 clears each status bit written as 1 and leaves the other bits unchanged. If a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofIn | input | 1 | First cycle of a frame; a byte may be valid in the same cycle |
| byteValid | input | 1 | One received byte this cycle |
| eofIn | input | 1 | Last cycle of a frame; error flags are valid |
| errOvf | input | 1 | Receive FIFO overflow flag, sampled with eofIn |
| errCrc | input | 1 | Bad CRC flag, sampled with eofIn |
| errOver | input | 1 | Oversize frame flag, sampled with eofIn |
| errUnder | input | 1 | Undersize frame flag, sampled with eofIn |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| frmDone | output | 1 | Frame ruling strobe |
| frmKeep | output | 1 | Frame kept, valid with frmDone |
| discardPulse | output | 1 | Frame dropped |
| earlyPulse | output | 1 | Twelfth byte accepted |
| goodPulse | output | 1 | Error-free frame ended |
| rxIrq | output | 1 | Level receive interrupt |

## Verification
The bench runs every combination of the four keep bits against every combination of the four error flags. A design with a swapped bit order, or one that drops a frame only when every flagged class is disabled, gives a wrong keep or discard in some of those cases. Frame lengths from 1 to 14 bytes catch an early pulse that comes one byte off, that fires for a short frame, or that is lost when the twelfth byte also ends the frame. A frame that is restarted part-way through exposes a byte counter that does not reset at start of frame. Partial clears, and a clear written in the same cycle as a set, catch a status register that clears too much or lets the clear win, as well as an interrupt that ignores the global mask.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int NUM_ERR = 4;
  localparam int STAT_W  = NUM_ERR + 2;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // control settings handed to the datapath
  typedef struct packed {
    logic               goodEn;
    logic               earlyEn;
    logic [NUM_ERR-1:0] keepErr;
  } rxCfg_t;

  // event strobes handed from the datapath to the control
  typedef struct packed {
    logic               good;
    logic               early;
    logic [NUM_ERR-1:0] errSeen;
  } rxEvt_t;

endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int EARLY_BYTES = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofIn,
  input  logic               byteValid,
  input  logic               eofIn,
  input  logic [NUM_ERR-1:0] errFlags,
  input  rxCfg_t             cfg,
  output rxEvt_t             evt,
  output logic               frmDone,
  output logic               frmKeep,
  output logic               discardPulse,
  output logic               goodPulse,
  output logic               earlyPulse
);

  localparam int CNT_W = $clog2(EARLY_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(EARLY_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(EARLY_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] cntBase;
  logic [CNT_W-1:0] cntNext;
  logic             inFrame;
  logic             active;
  logic             byteTake;
  logic             earlyHit;
  logic             endNow;
  logic             dropNow;
  logic             doneQ, keepQ, discardQ, goodQ;
  logic [NUM_ERR-1:0] errQ;

  always_comb begin
    active   = sofIn | inFrame;
    cntBase  = sofIn ? '0 : byteCnt;
    byteTake = active & byteValid;
    cntNext  = (byteTake && (cntBase < CNT_LIMIT)) ? cntBase + 1'b1 : cntBase;
    earlyHit = byteTake && (cntBase == CNT_LAST);
    endNow   = eofIn & active;
    dropNow  = |(errFlags & ~cfg.keepErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      inFrame  <= 1'b0;
      doneQ    <= 1'b0;
      keepQ    <= 1'b0;
      discardQ <= 1'b0;
      goodQ    <= 1'b0;
      errQ     <= '0;
    end else begin
      if (active) byteCnt <= cntNext;
      if (endNow)     inFrame <= 1'b0;
      else if (sofIn) inFrame <= 1'b1;
      doneQ    <= endNow;
      keepQ    <= endNow & ~dropNow;
      discardQ <= endNow & dropNow;
      goodQ    <= endNow & (errFlags == '0) & cfg.goodEn;
      errQ     <= endNow ? errFlags : '0;
    end
  end

  assign frmDone      = doneQ;
  assign frmKeep      = keepQ;
  assign discardPulse = discardQ;
  assign goodPulse    = goodQ;
  assign earlyPulse   = earlyHit & cfg.earlyEn;

  assign evt.good    = goodQ;
  assign evt.early   = earlyPulse;
  assign evt.errSeen = errQ;

  assert_done_after_eof_R3: assert property (@(posedge clk) disable iff (!rstN)
    frmDone |-> $past(eofIn));

  assert_discard_is_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> (frmDone && !frmKeep));

  assert_early_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    earlyPulse |=> !earlyPulse);

  assert_good_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    goodPulse |-> (frmDone && frmKeep));

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  rxEvt_t            evt,
  output rxCfg_t            cfg,
  output logic              rxIrq
);

  logic [DATA_W-1:0] cmdQ;
  logic              maskQ;
  logic [STAT_W-1:0] statQ;
  logic [STAT_W-1:0] statSet;
  logic [STAT_W-1:0] statClr;

  always_comb begin
    statSet = {evt.good, evt.early, evt.errSeen & cmdQ[NUM_ERR-1:0]};
    statClr = (regWrEn && regAddr == ADDR_STAT) ? regWrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      maskQ <= 1'b0;
      statQ <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_CMD)  cmdQ  <= regWrData;
      if (regWrEn && regAddr == ADDR_MASK) maskQ <= regWrData[0];
      statQ <= (statQ & ~statClr) | statSet;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CMD:  regRdData = cmdQ;
      ADDR_MASK: regRdData[0] = maskQ;
      ADDR_STAT: regRdData[STAT_W-1:0] = statQ;
      default:   regRdData = '0;
    endcase
  end

  assign cfg.keepErr = cmdQ[NUM_ERR-1:0];
  assign cfg.earlyEn = cmdQ[NUM_ERR];
  assign cfg.goodEn  = cmdQ[NUM_ERR+1];
  assign rxIrq       = (|statQ) & ~maskQ;

  assert_good_sets_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    evt.good |=> statQ[STAT_W-1]);

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ != '0) && !(regWrEn && regAddr == ADDR_STAT)) |=> (statQ != '0));

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int EARLY_BYTES = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofIn,
  input  logic       byteValid,
  input  logic       eofIn,
  input  logic       errOvf,
  input  logic       errCrc,
  input  logic       errOver,
  input  logic       errUnder,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       frmDone,
  output logic       frmKeep,
  output logic       discardPulse,
  output logic       earlyPulse,
  output logic       goodPulse,
  output logic       rxIrq
);

  rxCfg_t cfg;
  rxEvt_t evt;

  rxf_datapath #(.EARLY_BYTES(EARLY_BYTES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sofIn        (sofIn),
    .byteValid    (byteValid),
    .eofIn        (eofIn),
    .errFlags     ({errUnder, errOver, errCrc, errOvf}),
    .cfg          (cfg),
    .evt          (evt),
    .frmDone      (frmDone),
    .frmKeep      (frmKeep),
    .discardPulse (discardPulse),
    .goodPulse    (goodPulse),
    .earlyPulse   (earlyPulse)
  );

  rxf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .evt       (evt),
    .cfg       (cfg),
    .rxIrq     (rxIrq)
  );

endmodule

// File: tb/rx_accept_filter_test.sv
`timescale 1ns/1ps
module rx_accept_filter_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sofIn, byteValid, eofIn;
  logic [3:0] errs;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       frmDone, frmKeep, discardPulse, earlyPulse, goodPulse, rxIrq;

  int nTests = 0;
  int nFail  = 0;
  logic [7:0] curCmd = 8'h00;

  always #5 clk = ~clk;

  rx_accept_filter uut (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .byteValid(byteValid), .eofIn(eofIn),
    .errOvf(errs[0]), .errCrc(errs[1]), .errOver(errs[2]), .errUnder(errs[3]),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frmDone(frmDone), .frmKeep(frmKeep), .discardPulse(discardPulse),
    .earlyPulse(earlyPulse), .goodPulse(goodPulse), .rxIrq(rxIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands at the next posedge
  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) curCmd = d;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // drives a frame of len bytes from a negedge; returns at the negedge after the eof edge
  task automatic sendFrame(input int len, input logic [3:0] e, input string req);
    for (int i = 0; i < len; i++) begin
      sofIn = (i == 0); byteValid = 1'b1; eofIn = (i == len - 1);
      errs = (i == len - 1) ? e : 4'h0;
      #1;
      check(req, earlyPulse, (curCmd[4] && i == 11) ? 1 : 0);
      @(negedge clk);
    end
    sofIn = 1'b0; byteValid = 1'b0; eofIn = 1'b0; errs = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; sofIn = 1'b0; byteValid = 1'b0; eofIn = 1'b0; errs = 4'h0;
    regWrEn = 1'b0; regAddr = 2'd0; regWrData = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check("R1 reg", rd, 0);
    end
    check("R1 outputs", {frmDone, frmKeep, discardPulse, earlyPulse, goodPulse, rxIrq}, 0);

    // R2 readback of every command value, mask bit
    for (int v = 0; v < 256; v++) begin
      regWrite(2'd0, 8'(v));
      regRead(2'd0, rd);
      check("R2 cmd", rd, v);
    end
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, rd);
    check("R2 mask", rd, 1);
    regRead(2'd3, rd);
    check("R2 unused", rd, 0);
    regWrite(2'd1, 8'h00);

    // R3 R4 R5 R7 R8 R9: every keep setting against every error set
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 16; e++) begin
        automatic logic drop = |(4'(e) & ~4'(c));
        automatic logic msk  = c[0] ^ e[1];
        automatic logic [5:0] expStat = {(e == 0), 1'b0, 4'(e) & 4'(c)};
        regWrite(2'd0, {2'(c), 2'b10, 4'(c)});
        regWrite(2'd1, {7'd0, msk});
        regWrite(2'd2, 8'h3F);
        sendFrame(3, 4'(e), "R6 none");
        #1;
        check("R3 done", frmDone, 1);
        check("R3 keep", frmKeep, !drop);
        check("R4/R5 discard", discardPulse, drop);
        check("R7 good", goodPulse, (e == 0));
        @(negedge clk);
        check("R5 single discard", discardPulse, 0);
        regRead(2'd2, rd);
        check("R8 status", rd, expStat);
        check("R9 irq", rxIrq, (expStat != 0) && !msk);
      end
    end

    // R6 frame lengths around the twelfth byte
    for (int en = 0; en < 2; en++) begin
      for (int len = 1; len <= 14; len++) begin
        regWrite(2'd0, en ? 8'h10 : 8'h00);
        regWrite(2'd2, 8'h3F);
        sendFrame(len, 4'h0, "R6 early");
        @(negedge clk);
        regRead(2'd2, rd);
        check("R6/R8 early status", rd, (en && len >= 12) ? 8'h10 : 8'h00);
      end
    end

    // R6 restart at sof: 8 bytes with no eof, then a new 12-byte frame
    regWrite(2'd0, 8'h10);
    regWrite(2'd2, 8'h3F);
    for (int i = 0; i < 8; i++) begin
      sofIn = (i == 0); byteValid = 1'b1;
      #1 check("R6 partial", earlyPulse, 0);
      @(negedge clk);
    end
    sofIn = 1'b0; byteValid = 1'b0;
    sendFrame(12, 4'h0, "R6 restart");

    // R10 partial clear and set-wins
    regWrite(2'd0, 8'h2F);
    regWrite(2'd2, 8'h3F);
    sendFrame(2, 4'h5, "R6 none");
    @(negedge clk);
    regRead(2'd2, rd);
    check("R8 errs", rd, 8'h05);
    regWrite(2'd2, 8'h01);
    regRead(2'd2, rd);
    check("R10 partial clear", rd, 8'h04);
    check("R9 irq sticky", rxIrq, 1);
    regWrite(2'd2, 8'h04);
    regRead(2'd2, rd);
    check("R10 full clear", rd, 8'h00);
    check("R9 irq low", rxIrq, 0);
    sendFrame(2, 4'h0, "R6 none");
    // the status set edge is the next one: write the clear for bit 5 into it
    regWrite(2'd2, 8'h20);
    regRead(2'd2, rd);
    check("R10 set wins", rd, 8'h20);
    regWrite(2'd1, 8'h01);
    check("R9 masked", rxIrq, 0);
    regWrite(2'd1, 8'h00);
    check("R9 unmasked", rxIrq, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule